// File: doc/BRIEF.md
# Page Read ECC Status Collector

During a page read, a BCH decoder finishes the sectors of the page one at a time. This block takes in each result: the sector index, a 2-bit outcome and a 5-bit corrected-bit count. It stores one status byte per sector and packs four of those bytes into each 32-bit word. Software or a sequencer reads the words back through a plain address/data port. The block also keeps two summary outputs for the page: the worst correctable count and a sticky flag that is set when a sector cannot be corrected.

The number of sectors in the page follows from the configured page size and decoder step size. The number of status words that hold live data follows from that sector count. A small interrupt status vector holds two flags, one raised by a decoder error event and one raised by DMA completion. Each flag stays set until it is acknowledged.

Top module: `sector_ecc_collector`

## Requirements
- R1: After reset, every status word reads 0, `int_status` is 0, `max_errors` is 0 and `page_failed` is 0.
- R2: A status byte holds the outcome in bits [1:0] and the count in bits [6:2]; bit 7 is 0. Sector i sits in bits [8*(i%4)+7 : 8*(i%4)] of word i/4. The byte is readable on the cycle after the result is presented.
- R3: `page_size` 0 selects 2 KB, 1 selects 4 KB, and 2 or 3 selects 8 KB. `step_1k` 0 selects a 512-byte step and 1 selects a 1024-byte step. The sector count is page size divided by step size. `words_used` is the sector count divided by 4, and is 1 when the count is below 4.
- R4: A result whose sector index is not below the current sector count changes no status word, no flag and no summary output.
- R5: A read with `rd_addr` not below `words_used` returns 0, even when that word holds data from an earlier configuration.
- R6: Any result with a nonzero outcome sets `int_status[2]`. Bit 2 stays set until a cycle with `ack_ecc` high. When a set and an acknowledge fall in the same cycle, the set wins.
- R7: `dma_done` sets `int_status[0]`, and `ack_dma` clears it, with the set winning when both occur in the same cycle. `int_status[1]` always reads 0. Each flag is cleared independently of the other.
- R8: `max_errors` is the largest count carried by any correctable (outcome 01) result since the last page start. Counts carried with other outcomes do not change it.
- R9: An outcome of 10 or 11 sets `page_failed`. The flag stays set until the next page start.
- R10: `page_start` clears all status words, `max_errors` and `page_failed`, and drops any result presented in the same cycle. It leaves `int_status` untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_size | input | 2 | Page size select (2/4/8 KB) |
| step_1k | input | 1 | Decoder step: 0 = 512 B, 1 = 1024 B |
| page_start | input | 1 | Pulse at the start of a new page read |
| res_valid | input | 1 | A sector result is presented |
| res_sector | input | 4 | Sector index of the result |
| res_outcome | input | 2 | 00 clean, 01 corrected, 10/11 uncorrectable |
| res_count | input | 5 | Corrected bit count |
| dma_done | input | 1 | DMA completion event |
| ack_dma | input | 1 | Clears the DMA-done flag |
| ack_ecc | input | 1 | Clears the ECC flag |
| rd_addr | input | 2 | Status word address |
| rd_data | output | 32 | Addressed status word |
| words_used | output | 3 | Number of live status words |
| int_status | output | 3 | Bit 0 DMA done, bit 2 ECC event |
| max_errors | output | 5 | Worst correctable count this page |
| page_failed | output | 1 | Sticky uncorrectable flag |

## Verification
The bench builds the block with its default of 16 sectors per page. With that default, the 8 KB / 512-byte setting fills all four status words, so the top byte lane of the last word and every lane position can be reached. The smaller page settings can be switched in without a page start, which shows that words beyond `words_used` are masked on reads while their contents survive. The 2 KB / 1024-byte setting yields two sectors and exercises the one-word minimum.

// File: rtl/sector_ecc_pkg.sv
package sector_ecc_pkg;

  localparam int CNT_W = 5;

  typedef struct packed {
    logic             rsv;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       outc;
  } sec_stat_t;

  // Sectors per page from page size and step size.
  function automatic logic [7:0] fn_sector_count(input logic [1:0] size_sel,
                                                 input logic       step_big);
    logic [7:0] base;
    case (size_sel)
      2'd0:    base = 8'd4;
      2'd1:    base = 8'd8;
      default: base = 8'd16;
    endcase
    return step_big ? (base >> 1) : base;
  endfunction

  // Status words in use: one per four sectors, never fewer than one.
  function automatic logic [7:0] fn_words_used(input logic [7:0] sectors);
    return (sectors < 8'd4) ? 8'd1 : (sectors >> 2);
  endfunction

endpackage

// File: rtl/sec_status_bank.sv
module sec_status_bank
  import sector_ecc_pkg::*;
#(
  parameter int MAX_SECTORS = 16,
  localparam int IDX_W = $clog2(MAX_SECTORS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  sec_stat_t                wr_byte,
  output logic [MAX_SECTORS*8-1:0] bytes_flat
);

  logic [MAX_SECTORS-1:0] wr_stb;

  for (genvar i = 0; i < MAX_SECTORS; i++) begin : g_sec
    sec_stat_t cell_q;
    assign wr_stb[i] = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cell_q <= '0;
      else if (clr)       cell_q <= '0;
      else if (wr_stb[i]) cell_q <= wr_byte;
    end
    assign bytes_flat[i*8 +: 8] = cell_q;
  end

  AST_ONE_CELL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb)); // R2

  AST_CLEAR_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bytes_flat == '0)); // R10

endmodule

// File: rtl/page_summary.sv
module page_summary
  import sector_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rec_valid,
  input  logic [1:0]       rec_outc,
  input  logic [CNT_W-1:0] rec_cnt,
  output logic [CNT_W-1:0] max_errors,
  output logic             page_failed
);

  logic corr_evt, fail_evt;
  assign corr_evt = rec_valid && (rec_outc == 2'b01);
  assign fail_evt = rec_valid && rec_outc[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_errors  <= '0;
      page_failed <= 1'b0;
    end else if (clr) begin
      max_errors  <= '0;
      page_failed <= 1'b0;
    end else begin
      if (corr_evt && (rec_cnt > max_errors)) max_errors <= rec_cnt;
      if (fail_evt) page_failed <= 1'b1;
    end
  end

  AST_MAX_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (max_errors >= $past(max_errors))); // R8

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (page_failed && !clr) |=> page_failed); // R9

  AST_PAGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (max_errors == '0 && !page_failed)); // R10

endmodule

// File: rtl/ecc_event_flags.sv
module ecc_event_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ecc_evt,
  input  logic       dma_evt,
  input  logic       ack_ecc,
  input  logic       ack_dma,
  output logic [2:0] int_status
);

  logic ecc_q, dma_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecc_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      ecc_q <= ecc_evt | (ecc_q & ~ack_ecc);
      dma_q <= dma_evt | (dma_q & ~ack_dma);
    end
  end

  assign int_status = {ecc_q, 1'b0, dma_q};

  AST_ECC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_evt |=> int_status[2]); // R6

  AST_DMA_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_evt |=> int_status[0]); // R7

  AST_ECC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_ecc && !ecc_evt) |=> (int_status[2] == $past(int_status[2]))); // R6

endmodule

// File: rtl/sector_ecc_collector.sv
module sector_ecc_collector
  import sector_ecc_pkg::*;
#(
  parameter int MAX_SECTORS = 16,
  localparam int IDX_W  = $clog2(MAX_SECTORS),
  localparam int NWORDS = MAX_SECTORS / 4,
  localparam int ADDR_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int WU_W   = $clog2(NWORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        page_size,
  input  logic              step_1k,
  input  logic              page_start,
  input  logic              res_valid,
  input  logic [IDX_W-1:0]  res_sector,
  input  logic [1:0]        res_outcome,
  input  logic [CNT_W-1:0]  res_count,
  input  logic              dma_done,
  input  logic              ack_dma,
  input  logic              ack_ecc,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [WU_W-1:0]   words_used,
  output logic [2:0]        int_status,
  output logic [CNT_W-1:0]  max_errors,
  output logic              page_failed
);

  logic [7:0] sector_cnt_raw, sector_cnt, words_raw;
  logic       in_range, accept, ecc_evt;
  sec_stat_t  new_byte;
  logic [MAX_SECTORS*8-1:0] bytes_flat;

  assign sector_cnt_raw = fn_sector_count(page_size, step_1k);
  assign sector_cnt = (sector_cnt_raw > 8'(MAX_SECTORS)) ? 8'(MAX_SECTORS) : sector_cnt_raw;
  assign words_raw  = fn_words_used(sector_cnt);
  assign words_used = words_raw[WU_W-1:0];

  assign in_range = (8'(res_sector) < sector_cnt);
  assign accept   = res_valid && in_range && !page_start;
  assign ecc_evt  = accept && (res_outcome != 2'b00);
  assign new_byte = '{rsv: 1'b0, cnt: res_count, outc: res_outcome};

  sec_status_bank #(.MAX_SECTORS(MAX_SECTORS)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(page_start), .wr_en(accept),
    .wr_idx(res_sector), .wr_byte(new_byte), .bytes_flat(bytes_flat)
  );

  page_summary u_sum (
    .clk(clk), .rst_n(rst_n), .clr(page_start), .rec_valid(accept),
    .rec_outc(res_outcome), .rec_cnt(res_count),
    .max_errors(max_errors), .page_failed(page_failed)
  );

  ecc_event_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ecc_evt(ecc_evt), .dma_evt(dma_done),
    .ack_ecc(ack_ecc), .ack_dma(ack_dma), .int_status(int_status)
  );

  always_comb begin
    if (WU_W'(rd_addr) < words_used) rd_data = bytes_flat[rd_addr*32 +: 32];
    else                             rd_data = '0;
  end

  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !in_range && !page_start) |=> $stable(bytes_flat)); // R4

  AST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (WU_W'(rd_addr) >= words_used) |-> (rd_data == 32'h0)); // R5

  AST_WORDS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (words_used >= WU_W'(1))); // R3

endmodule

// File: tb/tb_sector_ecc_collector.sv
module tb_sector_ecc_collector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  page_size = 2'd0;
  logic        step_1k = 1'b0;
  logic        page_start = 1'b0;
  logic        res_valid = 1'b0;
  logic [3:0]  res_sector = '0;
  logic [1:0]  res_outcome = '0;
  logic [4:0]  res_count = '0;
  logic        dma_done = 1'b0, ack_dma = 1'b0, ack_ecc = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  words_used;
  logic [2:0]  int_status;
  logic [4:0]  max_errors;
  logic        page_failed;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  sector_ecc_collector dut (
    .clk(clk), .rst_n(rst_n), .page_size(page_size), .step_1k(step_1k),
    .page_start(page_start), .res_valid(res_valid), .res_sector(res_sector),
    .res_outcome(res_outcome), .res_count(res_count), .dma_done(dma_done),
    .ack_dma(ack_dma), .ack_ecc(ack_ecc), .rd_addr(rd_addr), .rd_data(rd_data),
    .words_used(words_used), .int_status(int_status), .max_errors(max_errors),
    .page_failed(page_failed)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane(input int sec, input int outc, input int cnt);
    return 32'((cnt * 4 + outc)) << (8 * (sec % 4));
  endfunction

  task automatic read_word(input int a, output logic [31:0] d);
    rd_addr = 2'(a);
    #1 d = rd_data;
  endtask

  task automatic send(input int sec, input int outc, input int cnt);
    @(negedge clk);
    res_valid = 1'b1; res_sector = 4'(sec); res_outcome = 2'(outc); res_count = 5'(cnt);
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic new_page(input int ps, input int st);
    @(negedge clk);
    page_size = 2'(ps); step_1k = st[0]; page_start = 1'b1;
    @(negedge clk);
    page_start = 1'b0;
  endtask

  task automatic pulse_ack(input bit a_dma, input bit a_ecc);
    @(negedge clk);
    ack_dma = a_dma; ack_ecc = a_ecc;
    @(negedge clk);
    ack_dma = 1'b0; ack_ecc = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    read_word(0, d);
    chk("R1 word0", d, 0);
    chk("R1 int_status", int_status, 0);
    chk("R1 max_errors", max_errors, 0);
    chk("R1 page_failed", page_failed, 0);
  endtask

  task automatic t_packing;
    logic [31:0] d;
    new_page(2, 0);
    chk("R3 8K/512 words", words_used, 4);
    send(5, 1, 3);
    send(15, 1, 9);
    send(0, 0, 0);
    read_word(1, d); chk("R2 sector5 lane", d, lane(5, 1, 3));
    read_word(3, d); chk("R2 sector15 lane", d, lane(15, 1, 9));
    read_word(0, d); chk("R2 sector0 clean", d, 0);
    send(12, 1, 31);
    read_word(3, d); chk("R2 word3 two lanes", d, lane(15, 1, 9) | lane(12, 1, 31));
    chk("R6 ecc flag set", int_status[2], 1);
    chk("R8 max tracks", max_errors, 31);
  endtask

  task automatic t_words;
    @(negedge clk); page_size = 2'd0; step_1k = 1'b1;
    #1 chk("R3 2K/1K words", words_used, 1);
    @(negedge clk); page_size = 2'd1; step_1k = 1'b0;
    #1 chk("R3 4K/512 words", words_used, 2);
    @(negedge clk); page_size = 2'd3; step_1k = 1'b1;
    #1 chk("R3 8K/1K words", words_used, 2);
    @(negedge clk); page_size = 2'd1; step_1k = 1'b1;
    #1 chk("R3 4K/1K words", words_used, 1);
  endtask

  task automatic t_range;
    logic [31:0] d;
    new_page(0, 0);
    pulse_ack(1'b1, 1'b1);
    send(4, 1, 7);
    send(9, 2, 3);
    chk("R4 no ecc flag", int_status[2], 0);
    chk("R4 max unchanged", max_errors, 0);
    chk("R4 no fail", page_failed, 0);
    @(negedge clk); page_size = 2'd2;
    read_word(1, d); chk("R4 word1 untouched", d, 0);
    read_word(2, d); chk("R4 word2 untouched", d, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    new_page(2, 0);
    send(9, 1, 4);
    @(negedge clk); page_size = 2'd1;
    read_word(2, d); chk("R5 masked read", d, 0);
    @(negedge clk); page_size = 2'd2;
    read_word(2, d); chk("R5 data kept", d, lane(9, 1, 4));
  endtask

  task automatic t_fail;
    logic [31:0] d;
    new_page(2, 0);
    send(1, 1, 6);
    send(2, 2, 20);
    read_word(0, d); chk("R2 uncorrectable byte", d, lane(1, 1, 6) | lane(2, 2, 20));
    chk("R9 failed set", page_failed, 1);
    chk("R8 uncorrectable count ignored", max_errors, 6);
    send(3, 1, 2);
    chk("R9 failed sticky", page_failed, 1);
    send(7, 3, 0);
    chk("R9 code 11 fails", page_failed, 1);
    chk("R8 smaller count keeps max", max_errors, 6);
  endtask

  task automatic t_irq;
    pulse_ack(1'b1, 1'b1);
    chk("R6 ack clears", int_status, 0);
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    chk("R7 dma flag", int_status, 3'b001);
    send(0, 1, 1);
    chk("R7 both flags, bit1 zero", int_status, 3'b101);
    pulse_ack(1'b1, 1'b0);
    chk("R7 dma ack independent", int_status, 3'b100);
    @(negedge clk); res_valid = 1'b1; res_sector = 4'd1; res_outcome = 2'd1;
    res_count = 5'd1; ack_ecc = 1'b1; dma_done = 1'b1; ack_dma = 1'b1;
    @(negedge clk); res_valid = 1'b0; ack_ecc = 1'b0; dma_done = 1'b0; ack_dma = 1'b0;
    chk("R6 R7 set beats ack", int_status, 3'b101);
    pulse_ack(1'b0, 1'b1);
    chk("R6 ecc ack", int_status, 3'b001);
  endtask

  task automatic t_start;
    logic [31:0] d;
    send(4, 2, 9);
    pulse_ack(1'b0, 1'b1);
    @(negedge clk);
    page_start = 1'b1; res_valid = 1'b1; res_sector = 4'd0;
    res_outcome = 2'd1; res_count = 5'd5;
    @(negedge clk);
    page_start = 1'b0; res_valid = 1'b0;
    read_word(0, d); chk("R10 word0 cleared, result dropped", d, 0);
    read_word(1, d); chk("R10 word1 cleared", d, 0);
    chk("R10 max cleared", max_errors, 0);
    chk("R10 fail cleared", page_failed, 0);
    chk("R10 ints untouched", int_status, 3'b001);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_packing();
    t_words();
    t_range();
    t_mask();
    t_fail();
    t_irq();
    t_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule